// File: doc/BRIEF.md
# Two-wire serial memory read port

This block is a two-wire bus target that sits in front of a byte memory of 4096 locations. It oversamples SCL and SDA with the system clock and recognises start, repeated start and stop conditions. It answers a 7-bit target address that is set by a parameter. A write transfer carrying two pointer bytes positions a shared address pointer. A read transfer then streams bytes from that pointer, most significant bit first, for as long as the bus master acknowledges each byte.

The pointer always names the byte after the most recent one served, so three kinds of read come from one mechanism. A read straight after start continues from where the last transfer left off. A pointer-only write followed by a repeated start and a read returns the byte at the chosen location. An acknowledged byte is followed by the next location, and the pointer wraps from the top of memory to zero. The block drives SDA only through an active-high pull-down enable. The system side can fill the memory through a simple write port.

The controller is one state machine:
- `ST_IDLE` waits for a start.
- `ST_DEV_RX` shifts in the target address and the direction bit. On a match it goes to `ST_ACK`; otherwise it goes to `ST_PARK`.
- `ST_HI_RX` and `ST_LO_RX` shift in the two pointer bytes, each going to `ST_ACK`.
- `ST_ACK` pulls SDA low for one SCL pulse. It then moves to the state stored for it: `ST_HI_RX`, `ST_LO_RX`, `ST_PARK`, or `ST_TX` with the first byte loaded.
- `ST_TX` shifts a byte out and then goes to `ST_MACK`.
- `ST_MACK` samples the master's answer. An acknowledge goes to `ST_MACK_GO`, which loads the next byte at the following SCL fall and returns to `ST_TX`. A not-acknowledge goes to `ST_IDLE`.
- `ST_PARK` leaves the bus alone.
- From every state, a stop goes to `ST_IDLE` and a start goes to `ST_DEV_RX`.

Top module: `twi_mem_reader`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and the address pointer is 0, so the first read returns location 0.
- R2: A start (SDA falling while SCL is high) or a stop (SDA rising while SCL is high) seen in any state abandons the transfer under way; an unfinished pointer byte leaves the pointer unchanged.
- R3: The first byte after start is the 7-bit target address, bits 7..1, followed by the direction bit, bit 0, where 1 means read. A matching address is acknowledged by pulling SDA low during the ninth SCL pulse. A non-matching address gets no acknowledge, and SDA stays released until the next start or stop.
- R4: In a write transfer, the two bytes after the address are the pointer, high byte first. Both are acknowledged, and only the low 4 bits of the high byte are kept.
- R5: A read returns the byte at the pointer, and the pointer then steps by one. A read that begins with no pointer write therefore continues from the byte after the last one served.
- R6: An acknowledge from the master after a data byte causes the next location to be sent. The pointer wraps from 4095 to 0.
- R7: A not-acknowledge after a data byte ends the read: SDA is released and the machine returns to idle.
- R8: Data go out most significant bit first. The target changes its SDA enable only while SCL is low, apart from an abort caused by a start or stop.
- R9: A write on the system fill port stores the byte at the given location, and a later bus read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| fill_we_i | input | 1 | Fill port write strobe |
| fill_addr_i | input | 12 | Fill port location |
| fill_data_i | input | 8 | Fill port byte |

## Verification
The memory is filled from a seeded random source. Seeded random pointer-then-read transfers of one to four bytes are then mixed with directed cases. Current-address reads with no pointer write show that the pointer persists and steps, rather than being reloaded. A high pointer byte with its upper bits set separates correct masking from a wrong location, and a stream across location 4095 exposes a missing wrap. A foreign target address, a stop in the middle of a pointer byte and a repeated start in the middle of a pointer byte each show that aborted or rejected traffic leaves both SDA and the pointer untouched.

// File: rtl/twi_rd_pkg.sv
package twi_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_RX,
        ST_HI_RX,
        ST_LO_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACK_GO,
        ST_PARK
    } twi_state_t;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_pipe;
    logic [1:0] sda_pipe;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_q    <= scl_pipe[1];
            sda_q    <= sda_pipe[1];
        end
    end

    assign scl_s     = scl_pipe[1];
    assign sda_s     = sda_pipe[1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    p_cond_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)));
endmodule

// File: rtl/twi_byte_mem.sv
module twi_byte_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/twi_mem_reader.sv
module twi_mem_reader
    import twi_rd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52,
    parameter int         ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              fill_we_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [7:0]        fill_data_i
);
    localparam int HI_KEEP = ADDR_W - BYTE_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_state_t           state, state_n;
    twi_state_t           ack_to, ack_to_n;
    logic [1:0]           ack_ph, ack_ph_n;
    logic [BIT_CNT_W-1:0] bit_cnt, bit_cnt_n;
    logic [BYTE_W-1:0]    rx_sh, rx_sh_n;
    logic [BYTE_W-1:0]    tx_sh, tx_sh_n;
    logic [BYTE_W-1:0]    hi_q, hi_n;
    logic                 pull_q, pull_n;

    logic                 ctr_load, ctr_step;
    logic [ADDR_W-1:0]    ctr_val, ptr;
    logic [BYTE_W-1:0]    rd_byte;
    logic [BYTE_W-1:0]    rx_full;

    twi_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctr_load),
        .load_val(ctr_val),
        .step    (ctr_step),
        .ptr     (ptr)
    );

    twi_byte_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk  (clk),
        .we   (fill_we_i),
        .waddr(fill_addr_i),
        .wdata(fill_data_i),
        .raddr(ptr),
        .rdata(rd_byte)
    );

    assign rx_full = {rx_sh[6:0], sda_s};
    assign ctr_val = {hi_q[HI_KEEP-1:0], rx_full};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ack_to  <= ST_IDLE;
            ack_ph  <= '0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            hi_q    <= '0;
            pull_q  <= 1'b0;
        end else begin
            state   <= state_n;
            ack_to  <= ack_to_n;
            ack_ph  <= ack_ph_n;
            bit_cnt <= bit_cnt_n;
            rx_sh   <= rx_sh_n;
            tx_sh   <= tx_sh_n;
            hi_q    <= hi_n;
            pull_q  <= pull_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        ack_to_n  = ack_to;
        ack_ph_n  = ack_ph;
        bit_cnt_n = bit_cnt;
        rx_sh_n   = rx_sh;
        tx_sh_n   = tx_sh;
        hi_n      = hi_q;
        pull_n    = pull_q;
        ctr_load  = 1'b0;
        ctr_step  = 1'b0;

        if (stop_det) begin
            state_n = ST_IDLE;
            pull_n  = 1'b0;
        end else if (start_det) begin
            state_n   = ST_DEV_RX;
            bit_cnt_n = '0;
            pull_n    = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_PARK: begin
                    pull_n = 1'b0;
                end
                ST_DEV_RX: begin
                    if (scl_rise) begin
                        rx_sh_n   = rx_full;
                        bit_cnt_n = bit_cnt + 1'b1;
                        if (bit_cnt == 4'd7) begin
                            if (rx_sh[6:0] == DEV_ADDR) begin
                                state_n  = ST_ACK;
                                ack_ph_n = 2'd0;
                                ack_to_n = sda_s ? ST_TX : ST_HI_RX;
                            end else begin
                                state_n = ST_PARK;
                            end
                        end
                    end
                end
                ST_HI_RX: begin
                    if (scl_rise) begin
                        rx_sh_n   = rx_full;
                        bit_cnt_n = bit_cnt + 1'b1;
                        if (bit_cnt == 4'd7) begin
                            hi_n     = rx_full;
                            state_n  = ST_ACK;
                            ack_ph_n = 2'd0;
                            ack_to_n = ST_LO_RX;
                        end
                    end
                end
                ST_LO_RX: begin
                    if (scl_rise) begin
                        rx_sh_n   = rx_full;
                        bit_cnt_n = bit_cnt + 1'b1;
                        if (bit_cnt == 4'd7) begin
                            ctr_load = 1'b1;
                            state_n  = ST_ACK;
                            ack_ph_n = 2'd0;
                            ack_to_n = ST_PARK;
                        end
                    end
                end
                ST_ACK: begin
                    unique case (ack_ph)
                        2'd0: begin
                            if (scl_fall) begin
                                pull_n   = 1'b1;
                                ack_ph_n = 2'd1;
                            end
                        end
                        2'd1: begin
                            if (scl_rise) begin
                                ack_ph_n = 2'd2;
                            end
                        end
                        default: begin
                            if (scl_fall) begin
                                bit_cnt_n = '0;
                                state_n   = ack_to;
                                if (ack_to == ST_TX) begin
                                    tx_sh_n  = rd_byte;
                                    pull_n   = ~rd_byte[7];
                                    ctr_step = 1'b1;
                                end else begin
                                    pull_n = 1'b0;
                                end
                            end
                        end
                    endcase
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt_n = bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            pull_n  = 1'b0;
                            state_n = ST_MACK;
                        end else begin
                            tx_sh_n = {tx_sh[6:0], 1'b0};
                            pull_n  = ~tx_sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        state_n = sda_s ? ST_IDLE : ST_MACK_GO;
                    end
                end
                ST_MACK_GO: begin
                    if (scl_fall) begin
                        bit_cnt_n = '0;
                        tx_sh_n   = rd_byte;
                        pull_n    = ~rd_byte[7];
                        ctr_step  = 1'b1;
                        state_n   = ST_TX;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    pull_n  = 1'b0;
                end
            endcase
        end
    end

    assign sda_pull_o = pull_q;

    p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    p_park_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK) |-> !sda_pull_o);

    p_low_phase_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sda_pull_o) && !$past(start_det || stop_det)) |-> !$past(scl_s));

    p_bitcnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    p_abort_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_DEV_RX && !sda_pull_o));
endmodule

// File: tb/twi_mem_reader_bench.sv
module twi_mem_reader_bench;
    localparam int          AW  = 12;
    localparam logic [6:0]  DEV = 7'h52;
    localparam int          Q   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pull;
    logic fill_we = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [7:0] fill_data = '0;
    wire  sda_line = sda_m & ~pull;

    int checks = 0;
    int fails = 0;
    int hi_glitch = 0;
    logic [7:0] exp_mem [4096];
    logic [AW-1:0] exp_ptr = '0;

    always #4 clk = ~clk;

    twi_mem_reader #(.DEV_ADDR(DEV), .ADDR_W(AW)) u_twi_mem_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .fill_we_i  (fill_we),
        .fill_addr_i(fill_addr),
        .fill_data_i(fill_data)
    );

    // R8 monitor: the enable may move only while SCL is low
    logic pull_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && pull !== pull_prev && scl_m) hi_glitch++;
        pull_prev <= pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ptr_of(input logic [7:0] hi, input logic [7:0] lo);
        return {hi[AW-9:0], lo};
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        scl_m = 1'b0; hold(Q);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(2 * Q);
    endtask

    task automatic bit_in(output logic b);
        scl_m = 1'b0; hold(Q);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        b = sda_line; hold(Q);
    endtask

    task automatic go_start();
        scl_m = 1'b0; hold(Q);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
    endtask

    task automatic go_stop();
        scl_m = 1'b0; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) bit_out(v[i]);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic a;
        send_bits(v, 8);
        bit_in(a);
        acked = (a == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic read_n(input int n, input string tag);
        logic [7:0] got;
        for (int k = 0; k < n; k++) begin
            recv_byte(got, k != n - 1);
            chk(got === exp_mem[exp_ptr], tag, got, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 1'b1;
        end
        chk(pull === 1'b0, "R7 released after not-acknowledge", pull, 0);
        go_stop();
    endtask

    task automatic cur_read(input int n, input string tag);
        bit a;
        go_start();
        send_byte({DEV, 1'b1}, a);
        chk(a, "R3 read address acknowledged", a, 1);
        read_n(n, tag);
    endtask

    task automatic rand_read(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
        bit a;
        go_start();
        send_byte({DEV, 1'b0}, a);
        chk(a, "R3 write address acknowledged", a, 1);
        send_byte(hi, a);
        chk(a, "R4 high pointer byte acknowledged", a, 1);
        send_byte(lo, a);
        chk(a, "R4 low pointer byte acknowledged", a, 1);
        exp_ptr = ptr_of(hi, lo);
        go_start();
        send_byte({DEV, 1'b1}, a);
        chk(a, "R3 repeated-start read acknowledged", a, 1);
        read_n(n, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit a;
        logic b;
        int lows;
        void'($urandom(32'h5eed_0042));
        hold(4);
        rst_n = 1'b1;
        hold(2);
        for (int i = 0; i < 4096; i++) begin
            fill_we   = 1'b1;
            fill_addr = AW'(i);
            fill_data = 8'($urandom);
            exp_mem[i] = fill_data;
            hold(1);
        end
        fill_we = 1'b0;
        hold(4);

        // R1 reset state
        chk(pull === 1'b0, "R1 enable released after reset", pull, 0);
        cur_read(1, "R1 R5 first read from location 0");

        // R5 current-address continuation
        cur_read(2, "R5 current-address read continues");

        // R4 masked high byte, R6 sequential
        rand_read(8'hF3, 8'h21, 4, "R4 R6 random then sequential read");
        cur_read(1, "R5 continues after random read");

        // R6 wrap
        rand_read(8'h0F, 8'hFE, 4, "R6 wrap from 4095 to 0");

        // R3 foreign address
        go_start();
        send_byte({DEV ^ 7'h01, 1'b1}, a);
        chk(!a, "R3 foreign address not acknowledged", a, 0);
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            bit_in(b);
            if (b == 1'b0) lows++;
        end
        chk(lows == 0, "R3 SDA left alone after foreign address", lows, 0);
        go_stop();
        cur_read(1, "R3 pointer untouched by foreign address");

        // R2 stop inside a pointer byte
        go_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h07, a);
        send_bits(8'h55, 4);
        go_stop();
        cur_read(1, "R2 stop mid-byte leaves pointer");

        // R2 repeated start inside a pointer byte
        go_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h02, a);
        send_bits(8'hAA, 3);
        cur_read(1, "R2 repeated start mid-byte leaves pointer");

        // R9 fill port write seen by the bus
        fill_we = 1'b1; fill_addr = 12'h4C7; fill_data = 8'h00;
        exp_mem[12'h4C7] = 8'h00;
        hold(1);
        fill_we = 1'b1; fill_addr = 12'h4C8; fill_data = 8'hFF;
        exp_mem[12'h4C8] = 8'hFF;
        hold(1);
        fill_we = 1'b0;
        rand_read(8'h04, 8'hC7, 2, "R9 R8 filled bytes read MSB first");

        // random mix
        for (int t = 0; t < 16; t++) begin
            logic [7:0] h, l;
            h = 8'($urandom);
            l = 8'($urandom);
            rand_read(h, l, 1 + int'($urandom % 4), "R4 R6 random pointer and length");
            if (t % 4 == 0) cur_read(1, "R5 random continuation");
        end

        chk(hi_glitch == 0, "R8 enable moved while SCL high", hi_glitch, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule